// File: doc/BRIEF.md
# Receiver Interrupt and Status Register

This block gathers five event lines from a packet receiver (receive-queue error, receive-queue nearly full, external pin event, good packet, failed checksum) into one 8-bit register that a host microcontroller reads over a simple register port. An active-low interrupt line tells the host when something needs attention.

Each event bit has two roles, and a separate 8-bit enable register picks the role. When the bit is enabled, it is a sticky flag. A 0-to-1 transition of its source sets it, it pulls the interrupt line low, and a host read of the status address clears it. When the bit is disabled, it is a plain status bit. It shows the source level as sampled, raises no interrupt, and no read clears it. The host reads both kinds of bit at the same address.

Top module: `rx_irq_status`

## Requirements
- R1: The event inputs map to status bits as follows: `ev_i[0]` to bit 0 (checksum failed), `ev_i[1]` to bit 1 (good packet), `ev_i[2]` to bit 3 (external event), `ev_i[3]` to bit 4 (receive queue nearly full), and `ev_i[4]` to bit 7 (receive queue over- or underrun).
- R2: Status bits 2, 5 and 6 always read as 0.
- R3: An enabled bit is set only by a 0-to-1 transition of its source. A source that stays high does not set the bit again after a clearing read.
- R4: `irq_n` is registered. It goes low on the clock edge that samples a rising source whose bit is enabled, and it stays high while no enabled bit is set.
- R5: A read of the status address (`STAT_ADDR`, default 3) returns the value held before that read. It also clears every enabled bit, so `irq_n` is high after that edge unless R8 applies.
- R6: A disabled bit reads the level of its source as registered on the previous edge. It never affects `irq_n`, and a read does not clear it.
- R7: The enable register sits at `EN_ADDR` (default 5). It can be written and read back, and reset sets it to 0x00.
- R8: If a source rises on the same edge as a clearing read, its bit stays set and `irq_n` stays low.
- R9: Enabling a bit while its source is already high raises no interrupt. The bit is set only by the next 0-to-1 transition.
- R10: Read data is registered. It appears on `rdata_o` one edge after `rd_i`, holds until the next read, and is 0x00 for any address other than the two registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_i | input | 5 | Raw event levels (see R1 for the mapping) |
| rd_i | input | 1 | Host read strobe, one cycle |
| wr_i | input | 1 | Host write strobe, one cycle |
| addr_i | input | 7 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt to the host, active low |

## Verification
The hardest case to reach from the ports is a source edge that falls in exactly the cycle of a clearing read. The bench drives the rising source and the read strobe on the same falling edge, so the latch sees the new event and the clear together. Enabling a bit while its source is already high is a second corner case. The bench reaches it by raising the source while the bit is disabled, writing the enable, and only later toggling the source. A behavioural model compares `irq_n` and read data on every clock across these sequences.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 5;
  localparam int REG_W = 8;

  // Status bit position of each event source.
  function automatic int src_pos(input int idx);
    case (idx)
      0: src_pos = 0;
      1: src_pos = 1;
      2: src_pos = 3;
      3: src_pos = 4;
      default: src_pos = 7;
    endcase
  endfunction
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] src_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) src_q[i] <= 1'b0;
      else     src_q[i] <= src_i[i];
    end
    assign rise_o[i] = src_i[i] & ~src_q[i];
  end

  assign lvl_o = src_q;
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] en_i,
  input  logic         clr_i,
  output logic [N-1:0] lat_o,
  output logic         irq_n
);
  logic [N-1:0] lat_q, lat_d;

  always_comb begin
    for (int i = 0; i < N; i++)
      lat_d[i] = en_i[i] & (rise_i[i] | (lat_q[i] & ~clr_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      irq_n <= 1'b1;
    end else begin
      lat_q <= lat_d;
      irq_n <= ~|lat_d;
    end
  end

  assign lat_o = lat_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R9
    en_late_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(en_i[i]) && !rise_i[i]) |=> !lat_q[i]);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (en_i[i] && lat_q[i] && !clr_i) |=> lat_q[i] || !$past(en_i[i]));
  end
endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs #(
  parameter int                W         = 8,
  parameter int                ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'd3,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 7'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      view_i,
  output logic [W-1:0]      en_o,
  output logic              clr_o,
  output logic [W-1:0]      rdata_o
);
  logic [W-1:0] en_q;

  assign clr_o = rd_i && (addr_i == STAT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_i && addr_i == EN_ADDR) en_q <= wdata_i;
      if (rd_i) begin
        if (addr_i == STAT_ADDR)    rdata_o <= view_i;
        else if (addr_i == EN_ADDR) rdata_o <= en_q;
        else                        rdata_o <= '0;
      end
    end
  end

  assign en_o = en_q;

  // R7
  en_rst_chk: assert property (@(posedge clk) rst |=> en_q == '0);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status
  import irq_pkg::*;
#(
  parameter int                ADDR_W    = 7,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 7'd3,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 7'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   ev_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_n
);
  logic [NSRC-1:0]  lvl, rise, lat, en_src;
  logic [REG_W-1:0] en_reg, view;
  logic             clr;

  irq_edge_det #(.N(NSRC)) u_edge (
    .clk(clk), .rst(rst), .src_i(ev_i), .lvl_o(lvl), .rise_o(rise)
  );

  irq_latch_bank #(.N(NSRC)) u_lat (
    .clk(clk), .rst(rst), .rise_i(rise), .en_i(en_src), .clr_i(clr),
    .lat_o(lat), .irq_n(irq_n)
  );

  irq_host_regs #(.W(REG_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
                  .EN_ADDR(EN_ADDR)) u_regs (
    .clk(clk), .rst(rst), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .view_i(view), .en_o(en_reg), .clr_o(clr),
    .rdata_o(rdata_o)
  );

  // Map sources into register bit positions; other positions stay 0.
  always_comb begin
    view = '0;
    for (int i = 0; i < NSRC; i++) begin
      en_src[i]          = en_reg[src_pos(i)];
      view[src_pos(i)]   = en_src[i] ? lat[i] : lvl[i];
    end
  end

  // R4
  rise_low_chk: assert property (@(posedge clk) disable iff (rst)
    (|(rise & en_src)) |=> !irq_n);
  // R5
  clr_high_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !(|(rise & en_src))) |=> irq_n);
  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == STAT_ADDR) |=> (rdata_o & 8'h64) == 8'h00);
  // R6
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en_src == '0) |=> irq_n);
endmodule

// File: tb/rx_irq_status_tb_top.sv
module rx_irq_status_tb_top;
  localparam int CLK_P = 10;
  localparam logic [6:0] A_ST = 7'd3, A_EN = 7'd5;

  logic       clk = 0, rst = 1;
  logic [4:0] ev = '0;
  logic       rd = 0, wr = 0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;

  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  rx_irq_status dut_i (
    .clk(clk), .rst(rst), .ev_i(ev), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_n(irq_n)
  );

  // Behavioural reference model
  int   pos[5] = '{0, 1, 3, 4, 7};
  bit   m_lat[8], m_en[8], m_src[5];
  bit [7:0] m_rd;
  bit   m_irq;
  int   n_clr;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_lat[k]) begin m_lat[k] = 0; m_en[k] = 0; end
      foreach (m_src[k]) m_src[k] = 0;
      m_rd = 0; m_irq = 1; n_clr = 0;
    end else begin
      bit [7:0] v, e;
      bit clr_now, any;
      v = 0; e = 0;
      for (int k = 0; k < 8; k++) e[k] = m_en[k];
      for (int i = 0; i < 5; i++)
        v[pos[i]] = m_en[pos[i]] ? m_lat[pos[i]] : m_src[i];
      clr_now = rd && addr == A_ST;
      any = 0;
      for (int i = 0; i < 5; i++) begin
        bit r;
        r = ev[i] && !m_src[i];
        if (m_en[pos[i]]) m_lat[pos[i]] = r || (m_lat[pos[i]] && !clr_now);
        else              m_lat[pos[i]] = 0;
        any |= m_lat[pos[i]];
      end
      if (rd) m_rd = (addr == A_ST) ? v : (addr == A_EN) ? e : 8'h00;
      if (wr && addr == A_EN) for (int k = 0; k < 8; k++) m_en[k] = wdata[k];
      for (int i = 0; i < 5; i++) m_src[i] = ev[i];
      m_irq = !any;
      if (clr_now) n_clr++;
    end
    #2;
    if (!rst) begin
      n_run++;
      if (irq_n !== m_irq) begin
        n_fail++;
        $display("FAIL model R4 irq_n: actual %b expected %b", irq_n, m_irq);
      end
      if (n_clr >= 2) begin
        n_run++;
        if (rdata !== m_rd) begin
          n_fail++;
          $display("FAIL model R10 rdata: actual %h expected %h", rdata, m_rd);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [6:0] a);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R4 reset irq_n", {7'd0, irq_n}, 8'h01);
    rd_reg(A_EN);
    chk("R7 enable reset", rdata, 8'h00);
    rd_reg(A_ST);               // first clearing read; contents not checked
    wr_reg(A_EN, 8'h9B);
    rd_reg(A_EN);
    chk("R7 enable readback", rdata, 8'h9B);
    // R1, R4, R5: good-packet pulse
    @(negedge clk); ev[1] = 1;
    @(negedge clk); ev[1] = 0;
    chk("R4 irq low after edge", {7'd0, irq_n}, 8'h00);
    rd_reg(A_ST);
    chk("R1 bit1 good packet", rdata, 8'h02);
    chk("R5 irq high after read", {7'd0, irq_n}, 8'h01);
    // R3: source held high sets only once
    @(negedge clk); ev[4] = 1;
    idle(3);
    rd_reg(A_ST);
    chk("R1 bit7 queue error", rdata, 8'h80);
    idle(2);
    rd_reg(A_ST);
    chk("R3 no reset by level", rdata, 8'h00);
    chk("R3 irq stays high", {7'd0, irq_n}, 8'h01);
    ev[4] = 0;
    // R6, R2: disabled bits are live and not cleared
    wr_reg(A_EN, 8'h00);
    @(negedge clk); ev = 5'h1F;
    idle(2);
    rd_reg(A_ST);
    chk("R2 reserved zero live", rdata, 8'h9B);
    chk("R6 no irq when disabled", {7'd0, irq_n}, 8'h01);
    rd_reg(A_ST);
    chk("R6 not cleared by read", rdata, 8'h9B);
    @(negedge clk); ev = 5'h08;
    idle(2);
    rd_reg(A_ST);
    chk("R1 bit4 nearly full", rdata, 8'h10);
    @(negedge clk); ev = 5'h01;
    idle(2);
    // R9: enable with source already high
    wr_reg(A_EN, 8'h01);
    idle(3);
    chk("R9 no irq on enable", {7'd0, irq_n}, 8'h01);
    rd_reg(A_ST);
    chk("R9 latch empty", rdata, 8'h00);
    @(negedge clk); ev[0] = 0;
    idle(2);
    @(negedge clk); ev[0] = 1;
    @(negedge clk);
    chk("R9 irq on next edge", {7'd0, irq_n}, 8'h00);
    rd_reg(A_ST);
    chk("R1 bit0 checksum", rdata, 8'h01);
    ev = '0;
    // R8: edge coincides with clearing read
    wr_reg(A_EN, 8'h9B);
    @(negedge clk); ev[2] = 1;
    @(negedge clk);
    chk("R4 irq on ext event", {7'd0, irq_n}, 8'h00);
    @(negedge clk); ev[2] = 0; ev[1] = 1; rd = 1; addr = A_ST;
    @(negedge clk); rd = 0;
    chk("R8 prior value returned", rdata, 8'h08);
    chk("R8 irq stays low", {7'd0, irq_n}, 8'h00);
    rd_reg(A_ST);
    chk("R8 new event kept", rdata, 8'h02);
    // R10: unmapped address reads zero
    rd_reg(7'd9);
    chk("R10 unmapped zero", rdata, 8'h00);
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule